// File: doc/BRIEF.md
# Per-Pin Interrupt Request Controller

This block watches a group of input pins, one per channel, and raises a separate interrupt request line for each channel. Pins may change at any time with respect to the clock. Each pin therefore passes through a two-stage synchroniser. The synchronised value is then compared with its value one clock earlier to find rising and falling edges.

Every channel works in one of two modes. An edge channel latches an event when an enabled rising or falling transition is seen, and software clears it by writing a one to the status word. A level channel drives its request straight from the synchronised pin, after applying its enable and polarity. The same pair of enable words has a different meaning in each mode: the rising word masks level channels, and the falling word picks their polarity.

Software reaches the block through a simple 32-bit word bus. Enables are changed through separate set and clear words, so no read-modify-write sequence is needed. Reads return data combinationally for the current address.

Top module: `pinirq_ctrl`

## Requirements
- R1: After reset, the mode, rising/level enable, falling/polarity and status words all read 0, and every `irq` output is low.
- R2: A write to offset 0x008 sets each rising/level enable bit whose data bit is 1. A write to offset 0x00C clears each such bit. Data bits of 0 leave enables unchanged. Offset 0x008 reads back the enables, and offset 0x00C reads 0.
- R3: A write to offset 0x014 sets each falling-enable/polarity bit whose data bit is 1. A write to offset 0x018 clears each such bit. Data bits of 0 leave these bits unchanged. Offset 0x014 reads back the bits, and offset 0x018 reads 0.
- R4: Offset 0x000 holds the mode word. Bit i = 1 makes channel i level-sensitive, and bit i = 0 makes it edge-sensitive. A write replaces the whole word, and a read returns it.
- R5: An edge channel latches an event on a rising pin edge when its rising enable is set, and on a falling edge when its falling enable is set; with both set, both edges count. The latched event drives `irq[i]` and status bit i at offset 0x024. It stays set until cleared, and a status write of 0 leaves it unchanged.
- R6: Writing 1 to status bit i clears the latched event of edge channel i. Writing all ones clears every pending edge event.
- R7: If an enabled edge and a write-one-to-clear of the same status bit take effect at the same clock edge, the status bit stays set.
- R8: A level channel drives `irq[i]` = rising/level enable AND (pin if the polarity bit is 1, else NOT pin). Its status bit reads this live value, and status writes have no effect on it.
- R9: A pin change sampled at clock edge k shows on a level channel's `irq` after edge k+1, and on an edge channel's `irq` after edge k+2.
- R10: Reads at offsets that are not part of the map return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 12 | Byte offset of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pins | input | 32 | Asynchronous input pins, one per channel |
| irq | output | 32 | Interrupt request, one line per channel |

## Verification
The assertions assume that at most one register word is written per cycle. They also assume that a mode change may clear a latched edge event without a status write. The random stimulus writes one word per operation and changes pins only between register operations. It then waits several clocks so that each edge is fully detected before the next operation, which keeps the bench's model exact. The event-against-clear collision and the synchroniser latency are reached with directed, cycle-aligned sequences instead.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;

    localparam int MAX_CH = 32;
    localparam int WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    // byte offsets that software relies on
    localparam logic [31:0] OFS_MODE  = 32'h000;
    localparam logic [31:0] OFS_SET_R = 32'h008;
    localparam logic [31:0] OFS_CLR_R = 32'h00C;
    localparam logic [31:0] OFS_SET_F = 32'h014;
    localparam logic [31:0] OFS_CLR_F = 32'h018;
    localparam logic [31:0] OFS_STAT  = 32'h024;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MODE,
        SEL_SET_R,
        SEL_CLR_R,
        SEL_SET_F,
        SEL_CLR_F,
        SEL_STAT
    } reg_sel_e;

    typedef struct packed {
        logic     we;
        reg_sel_e sel;
        word_t    data;
    } bus_req_t;

    function automatic reg_sel_e decode_addr(input logic [31:0] a);
        reg_sel_e s;
        case (a)
            OFS_MODE:  s = SEL_MODE;
            OFS_SET_R: s = SEL_SET_R;
            OFS_CLR_R: s = SEL_CLR_R;
            OFS_SET_F: s = SEL_SET_F;
            OFS_CLR_F: s = SEL_CLR_F;
            OFS_STAT:  s = SEL_STAT;
            default:   s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pinirq_sync.sv
module pinirq_sync #(
    parameter int NCH = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] pin_i,
    output logic [NCH-1:0] lvl_o,
    output logic [NCH-1:0] rise_o,
    output logic [NCH-1:0] fall_o
);
    logic [NCH-1:0] meta_q;
    logic [NCH-1:0] sync_q;
    logic [NCH-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign lvl_o  = sync_q;
    assign rise_o = sync_q & ~prev_q;
    assign fall_o = ~sync_q & prev_q;
endmodule

// File: rtl/pinirq_cfg.sv
module pinirq_cfg
    import pinirq_pkg::*;
#(
    parameter int NCH = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  bus_req_t       req,
    output logic [NCH-1:0] mode_o,
    output logic [NCH-1:0] en_r_o,
    output logic [NCH-1:0] en_f_o
);
    logic [NCH-1:0] wd;
    assign wd = req.data[NCH-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_o <= '0;
            en_r_o <= '0;
            en_f_o <= '0;
        end else if (req.we) begin
            case (req.sel)
                SEL_MODE:  mode_o <= wd;
                SEL_SET_R: en_r_o <= en_r_o | wd;
                SEL_CLR_R: en_r_o <= en_r_o & ~wd;
                SEL_SET_F: en_f_o <= en_f_o | wd;
                SEL_CLR_F: en_f_o <= en_f_o & ~wd;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pinirq_detect.sv
module pinirq_detect #(
    parameter int NCH = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] mode,
    input  logic [NCH-1:0] en_r,
    input  logic [NCH-1:0] en_f,
    input  logic [NCH-1:0] lvl,
    input  logic [NCH-1:0] rise,
    input  logic [NCH-1:0] fall,
    input  logic [NCH-1:0] clr,
    output logic [NCH-1:0] hit_o,
    output logic [NCH-1:0] st_o,
    output logic [NCH-1:0] irq_o
);
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic level_on;

        assign hit_o[i] = ~mode[i] & ((en_r[i] & rise[i]) | (en_f[i] & fall[i]));

        always_ff @(posedge clk) begin
            if (rst || mode[i]) st_o[i] <= 1'b0;
            else                st_o[i] <= hit_o[i] | (st_o[i] & ~clr[i]);
        end

        assign level_on = en_r[i] & (en_f[i] ? lvl[i] : ~lvl[i]);
        assign irq_o[i] = mode[i] ? level_on : st_o[i];
    end
endmodule

// File: rtl/pinirq_ctrl.sv
module pinirq_ctrl
    import pinirq_pkg::*;
#(
    parameter int NCH = 32,
    parameter int AW  = 12
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           bus_we,
    input  logic [AW-1:0]  bus_addr,
    input  logic [31:0]    bus_wdata,
    output logic [31:0]    bus_rdata,
    input  logic [NCH-1:0] pins,
    output logic [NCH-1:0] irq
);
    bus_req_t       req;
    logic [NCH-1:0] mode_q, en_r_q, en_f_q;
    logic [NCH-1:0] lvl_s, rise_s, fall_s;
    logic [NCH-1:0] clr_v, hit_v, st_v;

    assign req.we   = bus_we;
    assign req.sel  = decode_addr(32'(bus_addr));
    assign req.data = bus_wdata;

    assign clr_v = (bus_we && req.sel == SEL_STAT) ? bus_wdata[NCH-1:0] : '0;

    pinirq_sync #(.NCH(NCH)) u_sync (
        .clk(clk), .rst(rst), .pin_i(pins),
        .lvl_o(lvl_s), .rise_o(rise_s), .fall_o(fall_s)
    );

    pinirq_cfg #(.NCH(NCH)) u_cfg (
        .clk(clk), .rst(rst), .req(req),
        .mode_o(mode_q), .en_r_o(en_r_q), .en_f_o(en_f_q)
    );

    pinirq_detect #(.NCH(NCH)) u_det (
        .clk(clk), .rst(rst), .mode(mode_q), .en_r(en_r_q), .en_f(en_f_q),
        .lvl(lvl_s), .rise(rise_s), .fall(fall_s), .clr(clr_v),
        .hit_o(hit_v), .st_o(st_v), .irq_o(irq)
    );

    always_comb begin
        bus_rdata = '0;
        case (req.sel)
            SEL_MODE:  bus_rdata[NCH-1:0] = mode_q;
            SEL_SET_R: bus_rdata[NCH-1:0] = en_r_q;
            SEL_SET_F: bus_rdata[NCH-1:0] = en_f_q;
            SEL_STAT:  bus_rdata[NCH-1:0] = irq;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pinirq_ctrl_chk.sv
module pinirq_ctrl_chk #(
    parameter int NCH = 32,
    parameter int AW  = 12
) (
    input logic           clk,
    input logic           rst,
    input logic           bus_we,
    input logic [AW-1:0]  bus_addr,
    input logic [31:0]    bus_wdata,
    input logic [NCH-1:0] irq,
    input logic [NCH-1:0] mode,
    input logic [NCH-1:0] en_r,
    input logic [NCH-1:0] hit,
    input logic [NCH-1:0] st
);
    logic [NCH-1:0] wd;
    logic [NCH-1:0] stat_clr;
    assign wd       = bus_wdata[NCH-1:0];
    assign stat_clr = (bus_we && 32'(bus_addr) == 32'h024) ? wd : '0;

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (irq == '0));

    p_set_rise_en_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_we && 32'(bus_addr) == 32'h008) |=> ((en_r & $past(wd)) == $past(wd)));

    p_clr_rise_en_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_we && 32'(bus_addr) == 32'h00C) |=> ((en_r & $past(wd)) == '0));

    p_edge_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (st != '0) |=> (($past(st) & ~st & ~mode & ~$past(stat_clr)) == '0));

    p_event_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (hit != '0) |=> (((st | mode) & $past(hit)) == $past(hit)));

    p_level_masked_r8: assert property (@(posedge clk) disable iff (rst)
        (mode != '0) |-> ((irq & mode & ~en_r) == '0));
endmodule

bind pinirq_ctrl pinirq_ctrl_chk #(.NCH(NCH), .AW(AW)) u_chk (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .irq(irq), .mode(mode_q), .en_r(en_r_q),
    .hit(hit_v), .st(st_v)
);

// File: tb/pinirq_ctrl_test.sv
`timescale 1ns/1ps
module pinirq_ctrl_test;
    localparam int NCH = 32;
    localparam logic [11:0] A_MODE = 12'h000, A_SETR = 12'h008, A_CLRR = 12'h00C,
                            A_SETF = 12'h014, A_CLRF = 12'h018, A_STAT = 12'h024;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pins = '0;
    logic [31:0] irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    // bench model
    logic [31:0] m_mode, m_er, m_ef, m_st, m_pin;

    always #4 clk = ~clk;

    pinirq_ctrl #(.NCH(NCH), .AW(12)) uut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pins(pins), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 12'h000; bus_wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
        bus_addr = 12'h000;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; pins = '0;
        idle(3);
        rst = 1'b0;
        m_mode = '0; m_er = '0; m_ef = '0; m_st = '0; m_pin = '0;
    endtask

    function automatic logic [31:0] exp_irq();
        logic [31:0] lv;
        lv = m_er & ((m_ef & m_pin) | (~m_ef & ~m_pin));
        return (m_mode & lv) | (~m_mode & m_st);
    endfunction

    task automatic model_pins(input logic [31:0] p);
        logic [31:0] r, f;
        r = p & ~m_pin; f = ~p & m_pin;
        m_st = m_st | (~m_mode & ((r & m_er) | (f & m_ef)));
        m_pin = p;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        void'($urandom(32'd2024));
        do_reset();

        // R1: reset state
        rd(A_MODE, d); chk("R1 mode", d, 0);
        rd(A_SETR, d); chk("R1 rise/level enable", d, 0);
        rd(A_SETF, d); chk("R1 falling/polarity", d, 0);
        rd(A_STAT, d); chk("R1 status", d, 0);
        chk("R1 irq", irq, 0);

        // R2: set/clear of rising enables
        wr(A_SETR, 32'h5); wr(A_SETR, 32'h2); wr(A_SETR, 32'h0);
        rd(A_SETR, d); chk("R2 set accumulates", d, 32'h7);
        wr(A_CLRR, 32'h1);
        rd(A_SETR, d); chk("R2 clear one bit", d, 32'h6);
        rd(A_CLRR, d); chk("R2 clear word reads 0", d, 0);

        // R3: set/clear of falling enables
        wr(A_SETF, 32'hF0); wr(A_CLRF, 32'h30); wr(A_CLRF, 32'h0);
        rd(A_SETF, d); chk("R3 falling bits", d, 32'hC0);
        rd(A_CLRF, d); chk("R3 clear word reads 0", d, 0);

        // R4: mode word
        wr(A_MODE, 32'hA5A5_0000);
        rd(A_MODE, d); chk("R4 mode readback", d, 32'hA5A5_0000);
        wr(A_MODE, 32'h0);

        // R10: unmapped offsets
        rd(12'h004, d); chk("R10 unmapped 0x004", d, 0);
        rd(12'h020, d); chk("R10 unmapped 0x020", d, 0);

        // R5: ch0 rise only, ch1 fall only, ch2 both
        do_reset();
        wr(A_SETR, 32'h5); wr(A_SETF, 32'h6);
        pins = 32'h7; idle(4);
        chk("R5 rising edges", irq & 32'h7, 32'h5);
        wr(A_STAT, 32'h0); idle(1);
        chk("R5 status write of 0 keeps events", irq & 32'h7, 32'h5);
        rd(A_STAT, d); chk("R5 status readback", d & 32'h7, 32'h5);
        wr(A_STAT, 32'h1); idle(1);
        chk("R6 clear one event", irq & 32'h7, 32'h4);
        pins = 32'h0; idle(4);
        chk("R5 falling edges", irq & 32'h7, 32'h6);
        wr(A_STAT, 32'hFFFF_FFFF); idle(1);
        chk("R6 clear all", irq, 32'h0);

        // R9: edge latency (ch0 rising enabled)
        @(negedge clk); pins = 32'h1;
        @(negedge clk); chk("R9 edge not after 1 clock", irq & 32'h1, 0);
        @(negedge clk); chk("R9 edge not after 2 clocks", irq & 32'h1, 0);
        @(negedge clk); chk("R9 edge after 3 clocks", irq & 32'h1, 32'h1);

        // R7: new event beats simultaneous clear (ch0 already set)
        pins = 32'h0; idle(4);
        @(negedge clk); pins = 32'h1;
        @(negedge clk);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = A_STAT; bus_wdata = 32'h1;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 12'h000; bus_wdata = '0;
        chk("R7 event wins over clear", irq & 32'h1, 32'h1);
        wr(A_STAT, 32'h1); idle(1);
        chk("R7 plain clear afterwards", irq & 32'h1, 0);

        // R8: level channels 8 (active high) and 9 (active low)
        do_reset();
        wr(A_MODE, 32'h300); wr(A_SETF, 32'h100);
        chk("R8 level masked", irq, 0);
        wr(A_SETR, 32'h300); idle(1);
        chk("R8 pins low", irq, 32'h200);
        pins = 32'h300; idle(4);
        chk("R8 pins high", irq, 32'h100);
        wr(A_STAT, 32'h300); idle(1);
        rd(A_STAT, d); chk("R8 status write ignored", d, 32'h100);
        wr(A_CLRF, 32'h100); idle(1);
        chk("R8 polarity to low", irq, 32'h0);

        // R9: level latency on ch9 (active low, enabled)
        @(negedge clk); pins = 32'h100;
        @(negedge clk); chk("R9 level not after 1 clock", irq & 32'h200, 0);
        @(negedge clk); chk("R9 level after 2 clocks", irq & 32'h200, 32'h200);

        // random phase
        do_reset();
        for (int k = 0; k < 400; k++) begin
            int op;
            logic [31:0] v;
            op = $urandom % 7;
            v = $urandom;
            case (op)
                0, 1: begin
                    v = m_pin ^ ($urandom & $urandom);
                    pins = v; model_pins(v); idle(4);
                end
                2: begin wr(A_SETR, v); m_er = m_er | v; end
                3: begin wr(A_CLRR, v); m_er = m_er & ~v; end
                4: begin
                    if (v[0]) begin wr(A_SETF, v); m_ef = m_ef | v; end
                    else      begin wr(A_CLRF, v); m_ef = m_ef & ~v; end
                end
                5: begin v = $urandom & $urandom; wr(A_MODE, v); m_mode = v; m_st = m_st & ~v; end
                default: begin wr(A_STAT, v); m_st = m_st & ~v; end
            endcase
            idle(1);
            chk("R5/R8 random irq", irq, exp_irq());
            rd(A_STAT, d); chk("R6/R8 random status", d, exp_irq());
        end

        done = 1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule